// File: doc/BRIEF.md
# Multi-Polynomial Parallel PRBS Word Generator

This block drives the parallel word that feeds a serializer. It either forwards the normal datapath word or replaces it with a pseudo-random binary sequence test pattern. The pattern comes from one shared linear feedback shift register that can run any of five standard polynomials: PRBS7, PRBS9, PRBS15, PRBS23 and PRBS31. The register advances by a whole word on every clock. Words are 64 bits wide. PRBS9 can also run with 10-bit words, which suits lower line rates.

A small set of control inputs sets the pattern. These are a 4-bit pattern field, one extension bit, a narrow-word bit that only PRBS9 accepts, and an enable that gates the generator. Any select combination that is not defined, and a request for 10-bit words with a pattern other than PRBS9, both leave the datapath word on the output. The register never holds zero: it is seeded with all ones at reset and again whenever the select inputs change.

Top module: `prbs_word_gen`

## Requirements
- R1: Every pattern follows the recurrence b(n) = b(n-L) xor b(n-T). The pairs (L, T) are PRBS7 (7,6), PRBS9 (9,5), PRBS15 (15,14), PRBS23 (23,18) and PRBS31 (31,28). Bit 0 of `ser_word` holds the earliest serial bit and higher bits hold later ones. PRBS7 in 64-bit mode therefore repeats its word after 127 clocks.
- R2: The pattern is selected by `pat_field` together with `pat_ext`, read as {pat_field, pat_ext}:
  - 0001,0 selects PRBS7.
  - 0010,0 selects PRBS9.
  - 0100,0 selects PRBS15.
  - 1000,0 selects PRBS23.
  - 0000,1 selects PRBS31.
- R3: With PRBS9 selected and `narrow_sel`=1, `ser_word[9:0]` carries the next 10 sequence bits and `ser_word[63:10]` is zero. The sequence advances 10 bits per clock.
- R4: With `narrow_sel`=0, every pattern fills all 64 bits of `ser_word`. The sequence advances 64 bits per clock.
- R5: While `gen_en`=0, `ser_word` equals `dp_word` and the sequence state does not advance. When `gen_en` returns to 1 with an unchanged select, the sequence resumes exactly where it stopped.
- R6: While generation is active, `ser_word` carries only the pattern and does not depend on `dp_word`.
- R7: After reset, and in the same cycle that any of `pat_field`, `pat_ext` or `narrow_sel` differs from its value at the previous clock edge, the state is all ones. The first word output is the one generated from that all-ones seed, so the state is never zero.
- R8: Generation is off, and `ser_word` equals `dp_word`, in either of two cases: the select matches none of the combinations in R2, or `narrow_sel`=1 with any pattern other than PRBS9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_en | input | 1 | Generator clock enable; selects the pattern onto the output when the select is valid |
| pat_field | input | 4 | Nearly one-hot pattern select field |
| pat_ext | input | 1 | Extension select bit; only PRBS31 sets it |
| narrow_sel | input | 1 | 1 = 10-bit words (PRBS9 only), 0 = 64-bit words |
| dp_word | input | 64 | Normal datapath word |
| ser_word | output | 64 | Word delivered to the serializer |

## Verification
The assertions assume that the select inputs are only ever one of the defined combinations or some other fixed value, and that a change to them is held for at least one clock edge. They place no limit on how often `gen_en` toggles or on the value of `dp_word`. The stimulus changes controls only on the falling clock edge. Before each new pattern it parks the select at an all-zero value for one edge, so that the reseed happens in a known cycle. It also performs the direct pattern-to-pattern changes from R7 on purpose.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
  localparam int STATE_W = 31;

  typedef enum logic [2:0] {PAT_NONE, PAT_7, PAT_9, PAT_15, PAT_23, PAT_31} pat_e;

  function automatic pat_e decode_pat(input logic [3:0] fld, input logic ext);
    unique case ({fld, ext})
      5'b0001_0: decode_pat = PAT_7;
      5'b0010_0: decode_pat = PAT_9;
      5'b0100_0: decode_pat = PAT_15;
      5'b1000_0: decode_pat = PAT_23;
      5'b0000_1: decode_pat = PAT_31;
      default:   decode_pat = PAT_NONE;
    endcase
  endfunction

  // feedback length L and inner tap T of 1 + x^T + x^L
  function automatic logic [4:0] pat_len(input pat_e p);
    case (p)
      PAT_9:   pat_len = 5'd9;
      PAT_15:  pat_len = 5'd15;
      PAT_23:  pat_len = 5'd23;
      PAT_31:  pat_len = 5'd31;
      default: pat_len = 5'd7;
    endcase
  endfunction

  function automatic logic [4:0] pat_tap(input pat_e p);
    case (p)
      PAT_9:   pat_tap = 5'd5;
      PAT_15:  pat_tap = 5'd14;
      PAT_23:  pat_tap = 5'd18;
      PAT_31:  pat_tap = 5'd28;
      default: pat_tap = 5'd6;
    endcase
  endfunction
endpackage

// File: rtl/prbs_sel_decode.sv
module prbs_sel_decode
  import prbs_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gen_en,
  input  logic [3:0] pat_field,
  input  logic       pat_ext,
  input  logic       narrow_sel,
  output pat_e       pat,
  output logic       sel_valid,
  output logic       gen_active,
  output logic       sel_change
);
  logic [5:0] sel_now, sel_q;

  assign sel_now    = {pat_field, pat_ext, narrow_sel};
  assign pat        = decode_pat(pat_field, pat_ext);
  assign sel_valid  = (pat != PAT_NONE) && (!narrow_sel || pat == PAT_9);
  assign gen_active = gen_en && sel_valid;
  assign sel_change = (sel_now != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_now;
  end

  AST_ONEHOT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    gen_active |-> $onehot0(pat_field)); // R2
  AST_NARROW_ONLY_P9: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_active && narrow_sel) |-> (pat_field == 4'b0010 && !pat_ext)); // R3
endmodule

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
  import prbs_gen_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pat_e              pat,
  input  logic              narrow,
  input  logic              adv_en,
  input  logic              reload,
  output logic [WIDE_W-1:0] word
);
  localparam int RUN_W = STATE_W + WIDE_W;

  logic [STATE_W-1:0] state_q, eff_state, nxt_state;
  logic [RUN_W-1:0]   run_out;

  // Runs nbits serial steps from st; bit i of the word is step i's output.
  function automatic logic [RUN_W-1:0] run_bits(input logic [STATE_W-1:0] st,
                                                input logic [4:0] len,
                                                input logic [4:0] tap,
                                                input int nbits);
    logic [STATE_W-1:0] s;
    logic [WIDE_W-1:0]  w;
    logic [4:0]         ia, ib;
    logic               b;
    s  = st;
    w  = '0;
    ia = len - 5'd1;
    ib = tap - 5'd1;
    for (int i = 0; i < WIDE_W; i++) begin
      if (i < nbits) begin
        b    = s[ia] ^ s[ib];
        w[i] = b;
        s    = {s[STATE_W-2:0], b};
      end
    end
    return {s, w};
  endfunction

  assign eff_state = reload ? '1 : state_q;
  assign run_out   = run_bits(eff_state, pat_len(pat), pat_tap(pat),
                              narrow ? NARROW_W : WIDE_W);
  assign word      = run_out[WIDE_W-1:0];
  assign nxt_state = run_out[RUN_W-1:WIDE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= '1;
    else if (adv_en) state_q <= nxt_state;
    else             state_q <= eff_state;
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_en && !reload) |=> (state_q == $past(state_q))); // R5
  AST_RESEED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !adv_en) |=> (state_q == '1)); // R7
  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R7
endmodule

// File: rtl/prbs_out_mux.sv
module prbs_out_mux #(
  parameter int WIDE_W = 64
) (
  input  logic              use_gen,
  input  logic [WIDE_W-1:0] gen_word,
  input  logic [WIDE_W-1:0] dp_word,
  output logic [WIDE_W-1:0] out_word
);
  assign out_word = use_gen ? gen_word : dp_word;
endmodule

// File: rtl/prbs_word_gen.sv
module prbs_word_gen
  import prbs_gen_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic [3:0]        pat_field,
  input  logic              pat_ext,
  input  logic              narrow_sel,
  input  logic [WIDE_W-1:0] dp_word,
  output logic [WIDE_W-1:0] ser_word
);
  pat_e              pat;
  logic              sel_valid, gen_active, sel_change;
  logic [WIDE_W-1:0] gen_word;

  prbs_sel_decode u_dec (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .pat_field(pat_field),
    .pat_ext(pat_ext), .narrow_sel(narrow_sel), .pat(pat),
    .sel_valid(sel_valid), .gen_active(gen_active), .sel_change(sel_change)
  );

  prbs_lfsr_core #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_core (
    .clk(clk), .rst_n(rst_n), .pat(pat), .narrow(narrow_sel),
    .adv_en(gen_active), .reload(sel_change), .word(gen_word)
  );

  prbs_out_mux #(.WIDE_W(WIDE_W)) u_mux (
    .use_gen(gen_active), .gen_word(gen_word), .dp_word(dp_word),
    .out_word(ser_word)
  );

  AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> (ser_word == dp_word)); // R5
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && narrow_sel && pat_field == 4'b0010 && !pat_ext)
      |-> (ser_word[WIDE_W-1:NARROW_W] == '0)); // R3
  AST_BAD_SEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (ser_word == dp_word)); // R8
endmodule

// File: tb/prbs_word_gen_tb_top.sv
module prbs_word_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        gen_en;
  logic [3:0]  pat_field;
  logic        pat_ext;
  logic        narrow_sel;
  logic [63:0] dp_word;
  logic [63:0] ser_word;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [30:0] mh;
  int mL, mT;

  always #10 clk = ~clk;

  prbs_word_gen dut_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .pat_field(pat_field),
    .pat_ext(pat_ext), .narrow_sel(narrow_sel), .dp_word(dp_word),
    .ser_word(ser_word)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: b(n) = b(n-L) ^ b(n-T), history newest at bit 0
  task automatic model_word(input int nb, output logic [63:0] w);
    w = '0;
    for (int i = 0; i < nb; i++) begin
      logic b;
      b = mh[mL-1] ^ mh[mT-1];
      w[i] = b;
      mh = {mh[29:0], b};
    end
  endtask

  task automatic rnd_dp();
    dp_word = {$urandom, $urandom};
  endtask

  task automatic park();
    @(negedge clk);
    gen_en = 1'b0; pat_field = 4'b0000; pat_ext = 1'b0; narrow_sel = 1'b0;
    @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rnd_dp();
    #1 check(ser_word, dp_word, "R5 reset bypass");
  endtask

  task automatic t_pattern(input logic [3:0] f, input logic e, input int L, input int T,
                           input string tag);
    logic [63:0] exp;
    park();
    mh = '1; mL = L; mT = T;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) begin gen_en = 1'b1; pat_field = f; pat_ext = e; end
      rnd_dp();
      #1 model_word(64, exp);
      check(ser_word, exp, tag);
    end
  endtask

  task automatic t_narrow();
    logic [63:0] exp;
    park();
    mh = '1; mL = 9; mT = 5;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k == 0) begin gen_en = 1'b1; pat_field = 4'b0010; narrow_sel = 1'b1; end
      rnd_dp();
      #1 model_word(10, exp);
      check(ser_word, exp, "R3 PRBS9 10-bit word");
    end
    @(negedge clk);
    narrow_sel = 1'b0;
    mh = '1;
    #1 model_word(64, exp);
    check(ser_word, exp, "R7 reseed on width change");
  endtask

  task automatic t_hold();
    logic [63:0] exp;
    park();
    mh = '1; mL = 23; mT = 18;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (k == 0) begin gen_en = 1'b1; pat_field = 4'b1000; end
      #1 model_word(64, exp);
      check(ser_word, exp, "R4 PRBS23 before hold");
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      gen_en = 1'b0;
      rnd_dp();
      #1 check(ser_word, dp_word, "R5 disabled bypass");
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      gen_en = 1'b1;
      #1 model_word(64, exp);
      check(ser_word, exp, "R5 resume after hold");
    end
  endtask

  task automatic t_invalid();
    logic [4:0] bad [4] = '{5'b0011_0, 5'b0000_0, 5'b0001_1, 5'b1100_0};
    park();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      gen_en = 1'b1; {pat_field, pat_ext} = bad[k]; narrow_sel = 1'b0;
      rnd_dp();
      #1 check(ser_word, dp_word, "R8 undefined select");
    end
    @(negedge clk);
    {pat_field, pat_ext} = 5'b0001_0; narrow_sel = 1'b1;
    rnd_dp();
    #1 check(ser_word, dp_word, "R8 PRBS7 narrow rejected");
    @(negedge clk);
    {pat_field, pat_ext} = 5'b0000_1;
    rnd_dp();
    #1 check(ser_word, dp_word, "R8 PRBS31 narrow rejected");
  endtask

  task automatic t_reload();
    logic [63:0] exp;
    park();
    mh = '1; mL = 15; mT = 14;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k == 0) begin gen_en = 1'b1; pat_field = 4'b0100; end
      #1 model_word(64, exp);
    end
    check(ser_word, exp, "R7 PRBS15 third word");
    @(negedge clk);
    pat_field = 4'b0001;
    mh = '1; mL = 7; mT = 6;
    #1 model_word(64, exp);
    check(ser_word, exp, "R7 reseed on switch to PRBS7");
    @(negedge clk);
    pat_field = 4'b0100;
    mh = '1; mL = 15; mT = 14;
    #1 model_word(64, exp);
    check(ser_word, exp, "R7 reseed on switch back to PRBS15");
  endtask

  task automatic t_period();
    logic [63:0] w0;
    park();
    @(negedge clk);
    gen_en = 1'b1; pat_field = 4'b0001;
    #1 w0 = ser_word;
    for (int k = 0; k < 127; k++) @(negedge clk);
    #1 check(ser_word, w0, "R1 PRBS7 period 127 words");
    @(negedge clk);
    #1 n_chk++;
    if (ser_word === w0) begin
      n_fail++;
      $display("FAIL R1 word after period start actual=%h expected!=%h", ser_word, w0);
    end
  endtask

  initial begin
    rst_n = 1'b0; gen_en = 1'b0; pat_field = '0; pat_ext = 1'b0;
    narrow_sel = 1'b0; dp_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_pattern(4'b0001, 1'b0, 7, 6, "R2 R4 R6 PRBS7");
    t_pattern(4'b0010, 1'b0, 9, 5, "R2 R4 R6 PRBS9");
    t_pattern(4'b0100, 1'b0, 15, 14, "R2 R4 R6 PRBS15");
    t_pattern(4'b1000, 1'b0, 23, 18, "R2 R4 R6 PRBS23");
    t_pattern(4'b0000, 1'b1, 31, 28, "R1 R2 R6 PRBS31");
    t_narrow();
    t_hold();
    t_invalid();
    t_reload();
    t_period();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule